// File: doc/BRIEF.md
# Pipeline Hazard Resolution Unit

This unit sits beside the datapath of a five-stage in-order pipeline and produces every control that hazards need. For the instruction in execute it compares both source register numbers with the destination numbers of the two older instructions in memory and write-back. From that comparison it drives the two ALU operand multiplexer selects. It also signals when the write-back operand must come from loaded data.

In decode it watches for a load in execute whose target register is read by the decoding instruction. When it sees one, it freezes the PC and the fetch/decode register and turns the decoding instruction into a bubble. It also produces the flush controls for a branch resolved as taken in decode and for an arithmetic overflow raised in execute. On overflow it redirects the PC to a fixed exception vector.

The unit is purely combinational: every output follows the current inputs within the same cycle. The register data paths, the pipeline registers and the branch comparison are outside it.

Top module: `hazard_unit`

## Requirements
- R1: When a source register of the execute instruction equals `mem_rd`, `mem_reg_we` is 1 and `mem_rd` is nonzero, that operand's select is 2'b10 (execute/memory ALU result).
- R2: When a source register equals `wb_rd`, `wb_reg_we` is 1, `wb_rd` is nonzero and R1 does not apply to that operand, its select is 2'b01 (write-back value).
- R3: When both the memory and the write-back producers qualify for the same source register, the memory producer wins and the select is 2'b10.
- R4: A producer whose write enable is 0, or whose destination is register 0, never forwards. An operand with no qualifying producer has select 2'b00 (register file value), and the code 2'b11 never appears.
- R5: `fwd_wb_load` is 1 exactly when at least one operand select is 2'b01 and `wb_mem_to_reg` is 1. This tells the datapath to forward the loaded data rather than the ALU result.
- R6: When `ex_mem_read` is 1 and `ex_rt` equals `id_rs` or `id_rt`, and there is no overflow, `pc_write` and `ifid_write` are 0 and `idex_bubble` is 1. With `ex_mem_read` at 0, or with no register match, no stall is raised.
- R7: A taken branch (`id_br_taken`=1) with no stall and no overflow gives `ifid_flush`=1 and `idex_bubble`=1. `pc_write` stays 1 and `exmem_flush` stays 0.
- R8: While a load-use stall is active, a taken branch causes no flush: `ifid_flush` is 0 and the PC stays held.
- R9: When `ex_overflow` is 1, the unit drives `pc_exc_sel`=1, `pc_write`=1, `ifid_write`=1, `ifid_flush`=1, `idex_bubble`=1 and `exmem_flush`=1, whatever the other inputs are. `pc_exc_target` equals 0x40000040.
- R10: With no hazard, branch or overflow, `pc_write` and `ifid_write` are 1 and `ifid_flush`, `idex_bubble`, `exmem_flush` and `pc_exc_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute; load target when it reads memory |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_overflow | input | 1 | ALU overflow raised in execute |
| mem_rd | input | 5 | Destination register of the instruction in memory |
| mem_reg_we | input | 1 | Instruction in memory writes a register |
| wb_rd | input | 5 | Destination register of the instruction in write-back |
| wb_reg_we | input | 1 | Instruction in write-back writes a register |
| wb_mem_to_reg | input | 1 | Write-back value comes from loaded data |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| fwd_a_sel | output | 2 | First ALU operand select: 00 register file, 10 execute/memory, 01 write-back |
| fwd_b_sel | output | 2 | Second ALU operand select, same encoding |
| fwd_wb_load | output | 1 | A write-back forward must take the loaded data |
| pc_write | output | 1 | PC may update this cycle |
| ifid_write | output | 1 | Fetch/decode register may update this cycle |
| ifid_flush | output | 1 | Clear the fetch/decode instruction to a no-op |
| idex_bubble | output | 1 | Force every control entering execute to 0 |
| exmem_flush | output | 1 | Force every control entering memory to 0 |
| pc_exc_sel | output | 1 | PC input multiplexer takes the exception vector |
| pc_exc_target | output | 32 | Exception vector address |

## Verification
The forwarding selects are driven with register patterns that separate four cases: a match only in memory, a match only in write-back, matches in both on the same operand or on different operands, and producers that do not qualify (write enable low or destination zero). Each pattern exposes a different wrong priority or a missing qualifier. The decode side is tried with load matches on each source field separately and with a load that has no match. These cases tell apart a stall that compares the wrong field from one that ignores the read flag. A taken branch is applied alone, together with a stall, and together with an overflow, so that the ordering between the three disruptions is observable at the outputs.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [1:0] {
      FWD_RF    = 2'b00,
      FWD_MEMWB = 2'b01,
      FWD_EXMEM = 2'b10
   } fwd_sel_e;

   typedef struct packed {
      logic pc_write;
      logic ifid_write;
      logic ifid_flush;
      logic idex_bubble;
      logic exmem_flush;
      logic pc_exc_sel;
   } hz_ctl_t;

   localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
   parameter int unsigned REG_AW             = 5,
   parameter bit          ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_reg_we,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_reg_we,
   output hz_pkg::fwd_sel_e  sel
);

   logic mem_ok;
   logic wb_ok;
   logic hit_mem;
   logic hit_wb;

   generate
      if (ZERO_REG_HARDWIRED) begin : g_zero_skip
         assign mem_ok = mem_reg_we && (mem_rd != '0);
         assign wb_ok  = wb_reg_we  && (wb_rd  != '0);
      end else begin : g_zero_live
         assign mem_ok = mem_reg_we;
         assign wb_ok  = wb_reg_we;
      end
   endgenerate

   assign hit_mem = mem_ok && (mem_rd == src);
   assign hit_wb  = wb_ok  && (wb_rd  == src);

   always_comb begin
      if (hit_mem)     sel = hz_pkg::FWD_EXMEM;
      else if (hit_wb) sel = hz_pkg::FWD_MEMWB;
      else             sel = hz_pkg::FWD_RF;
   end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int unsigned REG_AW = 5
) (
   input  logic              ex_mem_read,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   output logic              load_use
);

   logic rs_dep;
   logic rt_dep;

   assign rs_dep   = (ex_rt == id_rs);
   assign rt_dep   = (ex_rt == id_rt);
   assign load_use = ex_mem_read && (rs_dep || rt_dep);

endmodule

// File: rtl/hz_flush_ctrl.sv
module hz_flush_ctrl (
   input  logic            load_use,
   input  logic            br_taken,
   input  logic            overflow,
   output hz_pkg::hz_ctl_t ctl
);

   logic hold;
   logic br_flush;

   // Overflow outranks the stall; the stall outranks the branch.
   assign hold     = load_use && !overflow;
   assign br_flush = br_taken && !hold;

   always_comb begin
      ctl             = '0;
      ctl.pc_write    = !hold;
      ctl.ifid_write  = !hold;
      ctl.ifid_flush  = overflow || br_flush;
      ctl.idex_bubble = overflow || hold || br_flush;
      ctl.exmem_flush = overflow;
      ctl.pc_exc_sel  = overflow;
   end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
   parameter int unsigned REG_AW             = 5,
   parameter int unsigned PC_W               = 32,
   parameter logic [31:0] EXC_VECTOR         = 32'h4000_0040,
   parameter bit          ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic [REG_AW-1:0] ex_rs,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic              ex_mem_read,
   input  logic              ex_overflow,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_reg_we,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_reg_we,
   input  logic              wb_mem_to_reg,
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic              id_br_taken,
   output logic [1:0]        fwd_a_sel,
   output logic [1:0]        fwd_b_sel,
   output logic              fwd_wb_load,
   output logic              pc_write,
   output logic              ifid_write,
   output logic              ifid_flush,
   output logic              idex_bubble,
   output logic              exmem_flush,
   output logic              pc_exc_sel,
   output logic [PC_W-1:0]   pc_exc_target
);

   localparam int unsigned NOPS = hz_pkg::NUM_OPERANDS;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hazard_unit: REG_AW must lie in 1..8");
      end
      if (PC_W < 2 || PC_W > 32) begin : g_bad_pcw
         $error("hazard_unit: PC_W must lie in 2..32");
      end
   endgenerate

   logic [NOPS-1:0][REG_AW-1:0] src_regs;
   hz_pkg::fwd_sel_e             sel [NOPS];
   logic [NOPS-1:0]              takes_wb;
   logic                         load_use;
   hz_pkg::hz_ctl_t              ctl;

   assign src_regs[0] = ex_rs;
   assign src_regs[1] = ex_rt;

   generate
      for (genvar g = 0; g < NOPS; g++) begin : g_opnd
         hz_fwd_sel #(
            .REG_AW             (REG_AW),
            .ZERO_REG_HARDWIRED (ZERO_REG_HARDWIRED)
         ) u_sel (
            .src        (src_regs[g]),
            .mem_rd     (mem_rd),
            .mem_reg_we (mem_reg_we),
            .wb_rd      (wb_rd),
            .wb_reg_we  (wb_reg_we),
            .sel        (sel[g])
         );
         assign takes_wb[g] = (sel[g] == hz_pkg::FWD_MEMWB);
      end
   endgenerate

   assign fwd_a_sel   = sel[0];
   assign fwd_b_sel   = sel[1];
   assign fwd_wb_load = wb_mem_to_reg && (|takes_wb);

   hz_load_use #(.REG_AW(REG_AW)) u_lu (
      .ex_mem_read (ex_mem_read),
      .ex_rt       (ex_rt),
      .id_rs       (id_rs),
      .id_rt       (id_rt),
      .load_use    (load_use)
   );

   hz_flush_ctrl u_fl (
      .load_use (load_use),
      .br_taken (id_br_taken),
      .overflow (ex_overflow),
      .ctl      (ctl)
   );

   assign pc_write      = ctl.pc_write;
   assign ifid_write    = ctl.ifid_write;
   assign ifid_flush    = ctl.ifid_flush;
   assign idex_bubble   = ctl.idex_bubble;
   assign exmem_flush   = ctl.exmem_flush;
   assign pc_exc_sel    = ctl.pc_exc_sel;
   assign pc_exc_target = EXC_VECTOR[PC_W-1:0];

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
   parameter int unsigned REG_AW             = 5,
   parameter bit          ZERO_REG_HARDWIRED = 1'b1
) (
   input logic [REG_AW-1:0] ex_rs,
   input logic [REG_AW-1:0] ex_rt,
   input logic              ex_mem_read,
   input logic              ex_overflow,
   input logic [REG_AW-1:0] mem_rd,
   input logic              mem_reg_we,
   input logic              wb_mem_to_reg,
   input logic [REG_AW-1:0] id_rs,
   input logic [REG_AW-1:0] id_rt,
   input logic              id_br_taken,
   input logic [1:0]        fwd_a_sel,
   input logic [1:0]        fwd_b_sel,
   input logic              fwd_wb_load,
   input logic              pc_write,
   input logic              ifid_write,
   input logic              ifid_flush,
   input logic              idex_bubble,
   input logic              exmem_flush,
   input logic              pc_exc_sel
);

   always_comb begin
      // R4: the unused select code never shows up
      p_sel_legal_r4: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
         else $error("select code 11 driven");
      // R1: an execute/memory forward needs a writing producer with the same register
      p_mem_source_r1: assert (fwd_a_sel != 2'b10 || (mem_reg_we && mem_rd == ex_rs))
         else $error("operand A forwarded from memory without a match");
      // R4: register 0 is never forwarded when hardwired
      p_no_zero_r4: assert (!ZERO_REG_HARDWIRED || ex_rs != '0 || fwd_a_sel == 2'b00)
         else $error("register 0 forwarded");
      // R5: a load forward flag needs a write-back select
      p_wb_load_r5: assert (!fwd_wb_load || (wb_mem_to_reg && (fwd_a_sel == 2'b01 || fwd_b_sel == 2'b01)))
         else $error("load forward flag without write-back select");
      // R6: a frozen front end always comes with a bubble and a held PC
      p_stall_hold_r6: assert (ifid_write || (!pc_write && idex_bubble))
         else $error("stall without bubble or with PC moving");
      // R8: no flush while held
      p_stall_no_flush_r8: assert (ifid_write || !ifid_flush)
         else $error("flush while stalled");
      // R9: exception redirect flushes every younger stage
      p_exc_redirect_r9: assert (!ex_overflow || (pc_exc_sel && pc_write && ifid_flush && idex_bubble && exmem_flush))
         else $error("overflow handling incomplete");
      // R10: nothing disturbs a quiet pipeline
      p_quiet_r10: assert (ex_overflow || id_br_taken || ex_mem_read ||
                           (pc_write && ifid_write && !ifid_flush && !idex_bubble && !exmem_flush && !pc_exc_sel))
         else $error("disruption on a quiet cycle");
   end

   // The decode register fields only matter together with the load flag.
   logic unused_ok;
   assign unused_ok = ^{ex_rt, id_rs, id_rt};

endmodule

bind hazard_unit hazard_unit_chk #(
   .REG_AW             (REG_AW),
   .ZERO_REG_HARDWIRED (ZERO_REG_HARDWIRED)
) u_chk (
   .ex_rs         (ex_rs),
   .ex_rt         (ex_rt),
   .ex_mem_read   (ex_mem_read),
   .ex_overflow   (ex_overflow),
   .mem_rd        (mem_rd),
   .mem_reg_we    (mem_reg_we),
   .wb_mem_to_reg (wb_mem_to_reg),
   .id_rs         (id_rs),
   .id_rt         (id_rt),
   .id_br_taken   (id_br_taken),
   .fwd_a_sel     (fwd_a_sel),
   .fwd_b_sel     (fwd_b_sel),
   .fwd_wb_load   (fwd_wb_load),
   .pc_write      (pc_write),
   .ifid_write    (ifid_write),
   .ifid_flush    (ifid_flush),
   .idex_bubble   (idex_bubble),
   .exmem_flush   (exmem_flush),
   .pc_exc_sel    (pc_exc_sel)
);

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC       = 9;
   localparam int  WATCHDOG   = 2000;

   typedef struct packed {
      logic [4:0] rs;
      logic [4:0] rt;
      logic [4:0] mrd;
      logic       mwe;
      logic [4:0] wrd;
      logic       wwe;
      logic       m2r;
      logic [1:0] exp_a;
      logic [1:0] exp_b;
      logic       exp_wbl;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0}, // R1 operand A from memory
      '{5'd3, 5'd4, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R1 operand B from memory
      '{5'd3, 5'd4, 5'd0, 1'b0, 5'd3, 1'b1, 1'b1, 2'b01, 2'b00, 1'b1}, // R2 R5 load value from write-back
      '{5'd5, 5'd5, 5'd9, 1'b1, 5'd5, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0}, // R2 both operands, ALU value
      '{5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 2'b10, 2'b10, 1'b0}, // R3 memory beats write-back
      '{5'd7, 5'd2, 5'd7, 1'b1, 5'd2, 1'b1, 1'b1, 2'b10, 2'b01, 1'b1}, // R3 R5 split sources
      '{5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0}, // R4 register 0
      '{5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0}, // R4 no write enables
      '{5'd8, 5'd9, 5'd8, 1'b0, 5'd8, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0}  // R4 memory not writing, write-back used
   };

   logic       clk = 1'b0;
   logic [4:0] ex_rs, ex_rt, mem_rd, wb_rd, id_rs, id_rt;
   logic       ex_mem_read, ex_overflow, mem_reg_we, wb_reg_we, wb_mem_to_reg, id_br_taken;
   logic [1:0] fwd_a_sel, fwd_b_sel;
   logic       fwd_wb_load, pc_write, ifid_write, ifid_flush, idex_bubble, exmem_flush, pc_exc_sel;
   logic [31:0] pc_exc_target;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hazard_unit u0 (
      .ex_rs (ex_rs), .ex_rt (ex_rt), .ex_mem_read (ex_mem_read), .ex_overflow (ex_overflow),
      .mem_rd (mem_rd), .mem_reg_we (mem_reg_we), .wb_rd (wb_rd), .wb_reg_we (wb_reg_we),
      .wb_mem_to_reg (wb_mem_to_reg), .id_rs (id_rs), .id_rt (id_rt), .id_br_taken (id_br_taken),
      .fwd_a_sel (fwd_a_sel), .fwd_b_sel (fwd_b_sel), .fwd_wb_load (fwd_wb_load),
      .pc_write (pc_write), .ifid_write (ifid_write), .ifid_flush (ifid_flush),
      .idex_bubble (idex_bubble), .exmem_flush (exmem_flush), .pc_exc_sel (pc_exc_sel),
      .pc_exc_target (pc_exc_target)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      ex_rs = '0; ex_rt = '0; mem_rd = '0; wb_rd = '0; id_rs = '0; id_rt = '0;
      ex_mem_read = 1'b0; ex_overflow = 1'b0; mem_reg_we = 1'b0; wb_reg_we = 1'b0;
      wb_mem_to_reg = 1'b0; id_br_taken = 1'b0;
   endtask

   // {pc_write, ifid_write, ifid_flush, idex_bubble, exmem_flush, pc_exc_sel}
   function automatic logic [5:0] ctl_word();
      return {pc_write, ifid_write, ifid_flush, idex_bubble, exmem_flush, pc_exc_sel};
   endfunction

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      clear_inputs();
      settle();
      // R10 idle state
      check("R10 idle controls", {26'd0, ctl_word()}, {26'd0, 6'b110000});
      check("R4 idle selects", {28'd0, fwd_a_sel, fwd_b_sel}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         clear_inputs();
         ex_rs = VECS[i].rs;  ex_rt = VECS[i].rt;
         mem_rd = VECS[i].mrd; mem_reg_we = VECS[i].mwe;
         wb_rd = VECS[i].wrd;  wb_reg_we = VECS[i].wwe; wb_mem_to_reg = VECS[i].m2r;
         settle();
         check($sformatf("R1-group vector %0d operand A", i), {30'd0, fwd_a_sel}, {30'd0, VECS[i].exp_a});
         check($sformatf("R1-group vector %0d operand B", i), {30'd0, fwd_b_sel}, {30'd0, VECS[i].exp_b});
         check($sformatf("R5 vector %0d load flag", i), {31'd0, fwd_wb_load}, {31'd0, VECS[i].exp_wbl});
      end

      // R6 stall through the first decode source
      clear_inputs(); ex_mem_read = 1'b1; ex_rt = 5'd4; id_rs = 5'd4; id_rt = 5'd1;
      settle();
      check("R6 stall on rs", {26'd0, ctl_word()}, {26'd0, 6'b000100});
      // R6 stall through the second decode source
      id_rs = 5'd1; id_rt = 5'd4;
      settle();
      check("R6 stall on rt", {26'd0, ctl_word()}, {26'd0, 6'b000100});
      // R6 load with no dependency
      id_rs = 5'd2; id_rt = 5'd3;
      settle();
      check("R6 no match no stall", {26'd0, ctl_word()}, {26'd0, 6'b110000});
      // R6 matching fields but not a load
      ex_mem_read = 1'b0; id_rs = 5'd4;
      settle();
      check("R6 not a load no stall", {26'd0, ctl_word()}, {26'd0, 6'b110000});

      // R7 taken branch alone
      clear_inputs(); id_br_taken = 1'b1;
      settle();
      check("R7 branch flush", {26'd0, ctl_word()}, {26'd0, 6'b111100});
      // R8 branch during a stall
      ex_mem_read = 1'b1; ex_rt = 5'd6; id_rs = 5'd6;
      settle();
      check("R8 stall suppresses branch flush", {26'd0, ctl_word()}, {26'd0, 6'b000100});

      // R9 overflow with a stall and a branch pending
      ex_overflow = 1'b1;
      settle();
      check("R9 overflow over stall", {26'd0, ctl_word()}, {26'd0, 6'b111111});
      check("R9 exception vector", pc_exc_target, 32'h4000_0040);
      // R9 overflow alone
      clear_inputs(); ex_overflow = 1'b1;
      settle();
      check("R9 overflow alone", {26'd0, ctl_word()}, {26'd0, 6'b111111});

      clear_inputs();
      settle();
      check("R10 back to quiet", {26'd0, ctl_word()}, {26'd0, 6'b110000});

      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule